// File: doc/BRIEF.md
# Event Control Sequencer for Reset, Interrupt, Call and Return

This block steps a processor through the multi-cycle work of its control events. After reset it fetches the start address from two fixed low memory words. On a non-maskable interrupt it pushes the return address and the condition flags onto a descending stack and fetches a handler address from a second vector pair. It also performs subroutine call, subroutine return and return from interrupt. Every transfer goes through a data memory made of 16-bit words, one access at a time, over a request/ready handshake.

A 32-bit value on the stack takes two words: the upper half at the slot address and the lower half one word below it. The upper half is always moved first. Each event ends with a one-cycle redirect pulse. The pulse carries the new program counter to fetch, raises a flush strobe, and commits the new stack pointer. A return from interrupt also commits the restored flags.

Control events are taken only between instructions. An interrupt that arrives while a sequence is running is held and serviced once that sequence ends. Reset wins over everything.

Top module: `evseq_ctrl`

## Requirements
- R1: While reset is asserted there is no memory request, no redirect and `ready_o` is low, and the stack pointer holds the top address (all ones). After release the block reads word 1 (upper half) and then word 0 (lower half) and redirects to their concatenation.
- R2: Every 32-bit transfer uses the upper half at address A first and the lower half at A-1 second. A request whose ready is low keeps its address, write enable and write data unchanged into the next cycle.
- R3: A rising edge on `nmi_i` starts an interrupt sequence when `ready_o` would otherwise be high. The sequence writes `cur_pc_i` to SP and SP-1. It then writes the flags, zero-extended to 32 bits, to SP-2 (word 0) and SP-3 (flags in bits 3:0). It lowers SP by 4 and redirects to {word 3, word 2}.
- R4: A call writes `cur_pc_i`+1 to SP and SP-1, lowers SP by 2 and redirects to `call_target_i`.
- R5: A return reads SP+2 (upper half) and SP+1 (lower half), redirects to that value and raises SP by 2.
- R6: A return from interrupt reads the program counter from SP+4 and SP+3, reads and discards SP+2, and takes the flags from bits 3:0 of SP+1. It raises SP by 4 and pulses `flags_load_o` with the redirect. No other event pulses `flags_load_o`.
- R7: An interrupt edge seen during any running sequence is latched and serviced as soon as that sequence completes, before any new command.
- R8: Commands are accepted only in a cycle where `ready_o` is high; otherwise they are ignored. When several are raised together, call beats return, which beats return from interrupt. `ready_o` is low while a sequence runs or an interrupt is pending.
- R9: Reset abandons any sequence in progress. An interrupt raised during the boot fetch is serviced after that fetch completes.
- R10: `redirect_o` and `flush_o` are single-cycle pulses in the cycle after the final handshake of a sequence. `pc_o` and `sp_o` change only in that cycle.
- R11: No memory request is issued while `ready_o` is high or in a redirect cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| nmi_i | input | 1 | Non-maskable interrupt request, edge detected |
| call_i | input | 1 | Start a subroutine call |
| ret_i | input | 1 | Start a subroutine return |
| rti_i | input | 1 | Start a return from interrupt |
| call_target_i | input | 2*DW | Destination of a call |
| cur_pc_i | input | 2*DW | Program counter of the instruction boundary |
| flags_i | input | FW | Current condition flags |
| ready_o | output | 1 | Idle with nothing pending; commands accepted |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | AW | Word address |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, valid while ready is high |
| mem_ready_i | input | 1 | Memory completes the access this cycle |
| redirect_o | output | 1 | New program counter valid (one cycle) |
| flush_o | output | 1 | Pipeline flush strobe |
| pc_o | output | 2*DW | New program counter |
| flags_load_o | output | 1 | Restored flags valid (one cycle) |
| flags_o | output | FW | Restored flags |
| sp_o | output | AW | Stack pointer |

## Verification
The properties assume that memory eventually raises ready for every request and that read data is valid in the ready cycle. They also assume commands are raised only as single-cycle strobes. The bench's memory model stalls for a programmable number of cycles and then acknowledges, and it returns the addressed word combinationally. The stimulus raises commands at the falling edge for one cycle and pulses the interrupt line for one cycle. Some commands and interrupt pulses are deliberately placed while the block is busy or in reset, which the block must ignore or latch.

// File: rtl/evseq_pkg.sv
package evseq_pkg;

    // Event under service
    typedef enum logic [2:0] {
        EV_BOOT = 3'd0,
        EV_NMI  = 3'd1,
        EV_CALL = 3'd2,
        EV_RET  = 3'd3,
        EV_RTI  = 3'd4
    } evt_e;

    // Where a read word is captured
    typedef enum logic [1:0] {
        CAP_NONE  = 2'd0,
        CAP_PC_HI = 2'd1,
        CAP_PC_LO = 2'd2,
        CAP_FLAGS = 2'd3
    } cap_e;

    localparam int STEP_W = 3;

endpackage

// File: rtl/evseq_nmi_catch.sv
module evseq_nmi_catch (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic nmi_i,
    input  logic take_i,
    output logic pending_o
);
    typedef struct packed {
        logic prev;
        logic pend;
    } nst_t;

    nst_t n_d, n_q;

    always_comb begin
        n_d      = n_q;
        n_d.prev = nmi_i;
        if (take_i) begin
            n_d.pend = 1'b0;
        end
        if (nmi_i && !n_q.prev) begin
            n_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            n_q <= '0;
        end else begin
            n_q <= n_d;
        end
    end

    assign pending_o = n_q.pend;

endmodule

// File: rtl/evseq_step.sv
module evseq_step
    import evseq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int FW = 4,
    localparam int PCW = 2 * DW
) (
    input  evt_e              evt_i,
    input  logic [STEP_W-1:0] step_i,
    input  logic [AW-1:0]     sp_i,
    input  logic [PCW-1:0]    save_i,
    input  logic [FW-1:0]     fsave_i,
    output logic              we_o,
    output logic              last_o,
    output cap_e              cap_o,
    output logic [AW-1:0]     addr_o,
    output logic [DW-1:0]     wdata_o,
    output logic [AW-1:0]     sp_end_o
);
    localparam logic [AW-1:0] VEC_BOOT_HI = AW'(1);
    localparam logic [AW-1:0] VEC_BOOT_LO = AW'(0);
    localparam logic [AW-1:0] VEC_NMI_HI  = AW'(3);
    localparam logic [AW-1:0] VEC_NMI_LO  = AW'(2);
    localparam logic [AW-1:0] ONE         = AW'(1);
    localparam logic [AW-1:0] TWO         = AW'(2);
    localparam logic [AW-1:0] THREE       = AW'(3);
    localparam logic [AW-1:0] FOUR        = AW'(4);

    logic [DW-1:0] save_hi;
    logic [DW-1:0] save_lo;
    logic [DW-1:0] flag_word;

    assign save_hi   = save_i[PCW-1:DW];
    assign save_lo   = save_i[DW-1:0];
    assign flag_word = DW'(fsave_i);

    always_comb begin
        we_o     = 1'b0;
        last_o   = 1'b0;
        cap_o    = CAP_NONE;
        addr_o   = sp_i;
        wdata_o  = '0;
        sp_end_o = sp_i;
        unique case (evt_i)
            EV_BOOT: begin
                if (step_i == '0) begin
                    addr_o = VEC_BOOT_HI;
                    cap_o  = CAP_PC_HI;
                end else begin
                    addr_o = VEC_BOOT_LO;
                    cap_o  = CAP_PC_LO;
                    last_o = 1'b1;
                end
            end
            EV_NMI: begin
                sp_end_o = sp_i - FOUR;
                we_o     = 1'b1;
                case (step_i)
                    3'd0: begin addr_o = sp_i;         wdata_o = save_hi;   end
                    3'd1: begin addr_o = sp_i - ONE;   wdata_o = save_lo;   end
                    3'd2: begin addr_o = sp_i - TWO;   wdata_o = '0;        end
                    3'd3: begin addr_o = sp_i - THREE; wdata_o = flag_word; end
                    3'd4: begin
                        we_o   = 1'b0;
                        addr_o = VEC_NMI_HI;
                        cap_o  = CAP_PC_HI;
                    end
                    default: begin
                        we_o   = 1'b0;
                        addr_o = VEC_NMI_LO;
                        cap_o  = CAP_PC_LO;
                        last_o = 1'b1;
                    end
                endcase
            end
            EV_CALL: begin
                sp_end_o = sp_i - TWO;
                we_o     = 1'b1;
                if (step_i == '0) begin
                    addr_o  = sp_i;
                    wdata_o = save_hi;
                end else begin
                    addr_o  = sp_i - ONE;
                    wdata_o = save_lo;
                    last_o  = 1'b1;
                end
            end
            EV_RET: begin
                sp_end_o = sp_i + TWO;
                if (step_i == '0) begin
                    addr_o = sp_i + TWO;
                    cap_o  = CAP_PC_HI;
                end else begin
                    addr_o = sp_i + ONE;
                    cap_o  = CAP_PC_LO;
                    last_o = 1'b1;
                end
            end
            default: begin
                sp_end_o = sp_i + FOUR;
                case (step_i)
                    3'd0: begin addr_o = sp_i + FOUR;  cap_o = CAP_PC_HI; end
                    3'd1: begin addr_o = sp_i + THREE; cap_o = CAP_PC_LO; end
                    3'd2: begin addr_o = sp_i + TWO;   cap_o = CAP_NONE;  end
                    default: begin
                        addr_o = sp_i + ONE;
                        cap_o  = CAP_FLAGS;
                        last_o = 1'b1;
                    end
                endcase
            end
        endcase
    end

endmodule

// File: rtl/evseq_ctrl.sv
module evseq_ctrl
    import evseq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int FW = 4,
    localparam int PCW = 2 * DW
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           nmi_i,
    input  logic           call_i,
    input  logic           ret_i,
    input  logic           rti_i,
    input  logic [PCW-1:0] call_target_i,
    input  logic [PCW-1:0] cur_pc_i,
    input  logic [FW-1:0]  flags_i,
    output logic           ready_o,
    output logic           mem_req_o,
    output logic           mem_we_o,
    output logic [AW-1:0]  mem_addr_o,
    output logic [DW-1:0]  mem_wdata_o,
    input  logic [DW-1:0]  mem_rdata_i,
    input  logic           mem_ready_i,
    output logic           redirect_o,
    output logic           flush_o,
    output logic [PCW-1:0] pc_o,
    output logic           flags_load_o,
    output logic [FW-1:0]  flags_o,
    output logic [AW-1:0]  sp_o
);
    localparam logic [AW-1:0] SP_TOP = '1;

    typedef struct packed {
        logic              busy;
        logic              boot;
        evt_e              evt;
        logic [STEP_W-1:0] step;
        logic [AW-1:0]     sp;
        logic [PCW-1:0]    save;
        logic [FW-1:0]     fsave;
        logic [PCW-1:0]    acc;
        logic [PCW-1:0]    pc;
        logic [FW-1:0]     flags;
        logic              redirect;
        logic              fload;
    } st_t;

    st_t s_d, s_q;

    logic          nmi_pend;
    logic          take_nmi;
    logic          st_we;
    logic          st_last;
    cap_e          st_cap;
    logic [AW-1:0] st_addr;
    logic [DW-1:0] st_wdata;
    logic [AW-1:0] st_sp_end;

    evseq_nmi_catch u_nmi (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .nmi_i     (nmi_i),
        .take_i    (take_nmi),
        .pending_o (nmi_pend)
    );

    evseq_step #(.AW(AW), .DW(DW), .FW(FW)) u_step (
        .evt_i    (s_q.evt),
        .step_i   (s_q.step),
        .sp_i     (s_q.sp),
        .save_i   (s_q.save),
        .fsave_i  (s_q.fsave),
        .we_o     (st_we),
        .last_o   (st_last),
        .cap_o    (st_cap),
        .addr_o   (st_addr),
        .wdata_o  (st_wdata),
        .sp_end_o (st_sp_end)
    );

    always_comb begin
        s_d          = s_q;
        s_d.redirect = 1'b0;
        s_d.fload    = 1'b0;
        take_nmi     = 1'b0;
        if (!s_q.busy) begin
            s_d.step = '0;
            if (s_q.boot) begin
                s_d.busy = 1'b1;
                s_d.boot = 1'b0;
                s_d.evt  = EV_BOOT;
            end else if (nmi_pend) begin
                take_nmi  = 1'b1;
                s_d.busy  = 1'b1;
                s_d.evt   = EV_NMI;
                s_d.save  = cur_pc_i;
                s_d.fsave = flags_i;
            end else if (call_i) begin
                s_d.busy = 1'b1;
                s_d.evt  = EV_CALL;
                s_d.save = cur_pc_i + PCW'(1);
                s_d.acc  = call_target_i;
            end else if (ret_i) begin
                s_d.busy = 1'b1;
                s_d.evt  = EV_RET;
            end else if (rti_i) begin
                s_d.busy = 1'b1;
                s_d.evt  = EV_RTI;
            end
        end else if (mem_ready_i) begin
            case (st_cap)
                CAP_PC_HI: s_d.acc[PCW-1:DW] = mem_rdata_i;
                CAP_PC_LO: s_d.acc[DW-1:0]   = mem_rdata_i;
                CAP_FLAGS: s_d.flags         = mem_rdata_i[FW-1:0];
                default:   ;
            endcase
            if (st_last) begin
                s_d.busy     = 1'b0;
                s_d.sp       = st_sp_end;
                s_d.pc       = s_d.acc;
                s_d.redirect = 1'b1;
                s_d.fload    = (s_q.evt == EV_RTI);
            end else begin
                s_d.step = s_q.step + STEP_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q      <= '0;
            s_q.boot <= 1'b1;
            s_q.sp   <= SP_TOP;
        end else begin
            s_q <= s_d;
        end
    end

    assign ready_o      = !s_q.busy && !s_q.boot && !nmi_pend;
    assign mem_req_o    = s_q.busy;
    assign mem_we_o     = s_q.busy && st_we;
    assign mem_addr_o   = st_addr;
    assign mem_wdata_o  = st_wdata;
    assign redirect_o   = s_q.redirect;
    assign flush_o      = s_q.redirect;
    assign pc_o         = s_q.pc;
    assign flags_load_o = s_q.fload;
    assign flags_o      = s_q.flags;
    assign sp_o         = s_q.sp;

endmodule

// File: rtl/evseq_ctrl_chk.sv
module evseq_ctrl_chk #(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int FW = 4,
    localparam int PCW = 2 * DW
) (
    input logic           clk_i,
    input logic           rst_ni,
    input logic           nmi_i,
    input logic           call_i,
    input logic           ret_i,
    input logic           rti_i,
    input logic [PCW-1:0] call_target_i,
    input logic [PCW-1:0] cur_pc_i,
    input logic [FW-1:0]  flags_i,
    input logic           ready_o,
    input logic           mem_req_o,
    input logic           mem_we_o,
    input logic [AW-1:0]  mem_addr_o,
    input logic [DW-1:0]  mem_wdata_o,
    input logic [DW-1:0]  mem_rdata_i,
    input logic           mem_ready_i,
    input logic           redirect_o,
    input logic           flush_o,
    input logic [PCW-1:0] pc_o,
    input logic           flags_load_o,
    input logic [FW-1:0]  flags_o,
    input logic [AW-1:0]  sp_o
);
    // R2: a stalled access keeps its address, direction and data
    p_req_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_o && !mem_ready_i) |=>
            (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));

    // R11: no access while idle and accepting
    p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ready_o |-> !mem_req_o);

    // R11: no access in the redirect cycle
    p_redirect_no_req_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        redirect_o |-> !mem_req_o);

    // R10: redirect lasts one cycle
    p_redirect_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        redirect_o |=> !redirect_o);

    // R10: stack pointer commits only with a redirect
    p_sp_at_end_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(sp_o) |-> redirect_o);

    // R10: program counter commits only with a redirect
    p_pc_at_end_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(pc_o) |-> redirect_o);

    // R6: flags are delivered with a redirect
    p_flags_with_redirect_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flags_load_o |-> redirect_o);

endmodule

bind evseq_ctrl evseq_ctrl_chk #(.AW(AW), .DW(DW), .FW(FW)) u_chk (.*);

// File: tb/evseq_ctrl_test.sv
module evseq_ctrl_test;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int FW = 4;

    localparam logic [2:0] K_CALL = 3'd1;
    localparam logic [2:0] K_RET  = 3'd2;
    localparam logic [2:0] K_RTI  = 3'd3;
    localparam logic [2:0] K_NMI  = 3'd4;

    localparam logic [31:0] BOOT_PC = 32'h1234_5678;
    localparam logic [31:0] NMI_PC  = 32'h00AB_BEEF;

    typedef struct packed {
        logic [2:0]  kind;
        logic [31:0] tgt;
        logic [31:0] cur;
        logic [3:0]  fl;
        logic [3:0]  lat;
        logic [31:0] epc;
        logic [7:0]  esp;
        logic [3:0]  efl;
    } row_t;

    localparam int NROWS = 8;
    localparam row_t TBL [NROWS] = '{
        '{K_CALL, 32'h0000_1000, 32'h0000_0020, 4'h0, 4'd0, 32'h0000_1000, 8'd253, 4'h0}, // R4
        '{K_CALL, 32'hCAFE_0000, 32'h0000_FFFF, 4'h0, 4'd1, 32'hCAFE_0000, 8'd251, 4'h0}, // R4
        '{K_RET,  32'h0,         32'h0,         4'h0, 4'd2, 32'h0001_0000, 8'd253, 4'h0}, // R5
        '{K_NMI,  32'h0,         32'h1111_2222, 4'hA, 4'd0, NMI_PC,        8'd249, 4'h0}, // R3
        '{K_CALL, 32'h0000_0040, 32'h00AB_BEF0, 4'h0, 4'd3, 32'h0000_0040, 8'd247, 4'h0}, // R4
        '{K_RET,  32'h0,         32'h0,         4'h0, 4'd1, 32'h00AB_BEF1, 8'd249, 4'h0}, // R5
        '{K_RTI,  32'h0,         32'h0,         4'h0, 4'd2, 32'h1111_2222, 8'd253, 4'hA}, // R6
        '{K_RET,  32'h0,         32'h0,         4'h0, 4'd0, 32'h0000_0021, 8'd255, 4'h0}  // R5
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          nmi = 1'b0, call = 1'b0, ret = 1'b0, rti = 1'b0;
    logic [31:0]   tgt = '0, cur = '0;
    logic [3:0]    fl = '0;
    logic          ready, mem_req, mem_we, mem_ready, redirect, flush, fload;
    logic [AW-1:0] mem_addr, sp;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic [31:0]   pc;
    logic [3:0]    flags;

    int total = 0;
    int bad   = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    evseq_ctrl #(.AW(AW), .DW(DW), .FW(FW)) uut (
        .clk_i(clk), .rst_ni(rst_n), .nmi_i(nmi), .call_i(call), .ret_i(ret), .rti_i(rti),
        .call_target_i(tgt), .cur_pc_i(cur), .flags_i(fl), .ready_o(ready),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ready_i(mem_ready),
        .redirect_o(redirect), .flush_o(flush), .pc_o(pc), .flags_load_o(fload),
        .flags_o(flags), .sp_o(sp)
    );

    // memory model with programmable wait states
    logic [DW-1:0] mem [0:(1<<AW)-1];
    int wcnt = 0;
    int lat  = 0;
    assign mem_ready = mem_req && (wcnt >= lat);
    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < (1 << AW); i++) mem[i] <= '0;
            mem[0] <= BOOT_PC[15:0];
            mem[1] <= BOOT_PC[31:16];
            mem[2] <= NMI_PC[15:0];
            mem[3] <= NMI_PC[31:16];
            wcnt   <= 0;
        end else begin
            if (mem_req && !mem_ready) wcnt <= wcnt + 1;
            else                       wcnt <= 0;
            if (mem_req && mem_ready && mem_we) mem[mem_addr] <= mem_wdata;
        end
    end

    // log of completed access addresses
    logic [AW-1:0] alog [0:127];
    int an = 0;
    always @(negedge clk) begin
        if (rst_n && mem_req && mem_ready && an < 128) begin
            alog[an] = mem_addr;
            an = an + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wait_ready();
        int n = 0;
        @(negedge clk);
        while (!ready && n < 400) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic wait_redirect(input string req);
        int n = 0;
        @(negedge clk);
        while (!redirect && n < 400) begin
            @(negedge clk);
            n++;
        end
        chk({req, " redirect seen"}, {31'd0, redirect}, 32'd1);
    endtask

    task automatic issue(input logic [2:0] kind);
        wait_ready();
        case (kind)
            K_CALL:  call = 1'b1;
            K_RET:   ret  = 1'b1;
            K_RTI:   rti  = 1'b1;
            default: nmi  = 1'b1;
        endcase
        @(negedge clk);
        call = 1'b0; ret = 1'b0; rti = 1'b0; nmi = 1'b0;
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int base;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 sp at top in reset", {24'd0, sp}, 32'd255);
        chk("R1 no request in reset", {31'd0, mem_req}, 32'd0);
        chk("R1 not ready in reset", {31'd0, ready}, 32'd0);
        chk("R1 no redirect in reset", {31'd0, redirect}, 32'd0);
        base = an;
        rst_n = 1'b1;
        wait_redirect("R1");
        chk("R1 boot pc", pc, BOOT_PC);
        chk("R1 boot sp", {24'd0, sp}, 32'd255);
        chk("R2 boot first addr", {24'd0, alog[base]}, 32'd1);
        chk("R2 boot second addr", {24'd0, alog[base+1]}, 32'd0);

        // vector table walk
        for (int i = 0; i < NROWS; i++) begin
            lat = int'(TBL[i].lat);
            tgt = TBL[i].tgt;
            cur = TBL[i].cur;
            fl  = TBL[i].fl;
            issue(TBL[i].kind);
            wait_redirect("R10 table");
            chk($sformatf("R10 row %0d pc", i), pc, TBL[i].epc);
            chk($sformatf("R10 row %0d sp", i), {24'd0, sp}, {24'd0, TBL[i].esp});
            chk($sformatf("R10 row %0d flush", i), {31'd0, flush}, 32'd1);
            if (TBL[i].kind == K_RTI) begin
                chk("R6 flags load", {31'd0, fload}, 32'd1);
                chk("R6 flags value", {28'd0, flags}, {28'd0, TBL[i].efl});
            end else begin
                chk("R6 no flags load", {31'd0, fload}, 32'd0);
            end
            @(negedge clk);
            chk("R10 redirect one cycle", {31'd0, redirect}, 32'd0);
        end
        chk("R4 call saved hi", {16'd0, mem[255]}, 32'h0000);
        chk("R4 call saved lo", {16'd0, mem[254]}, 32'h0021);
        chk("R3 pc hi on stack", {16'd0, mem[253]}, 32'h1111);
        chk("R3 pc lo on stack", {16'd0, mem[252]}, 32'h2222);
        chk("R3 flags hi word", {16'd0, mem[251]}, 32'h0000);
        chk("R3 flags lo word", {16'd0, mem[250]}, 32'h000A);

        // R7 / R8: interrupt and return arrive while a call runs
        lat = 3;
        tgt = 32'h0000_0200;
        cur = 32'h0000_0300;
        fl  = 4'h5;
        issue(K_CALL);
        base = an;
        nmi = 1'b1;
        ret = 1'b1;
        @(negedge clk);
        nmi = 1'b0;
        ret = 1'b0;
        chk("R8 not ready while busy", {31'd0, ready}, 32'd0);
        wait_redirect("R7 call");
        chk("R7 call pc", pc, 32'h0000_0200);
        chk("R7 call sp", {24'd0, sp}, 32'd253);
        chk("R8 not ready with pending interrupt", {31'd0, ready}, 32'd0);
        wait_redirect("R7 nmi");
        chk("R7 nmi pc", pc, NMI_PC);
        chk("R8 ignored return left sp", {24'd0, sp}, 32'd249);
        chk("R4 return address lo", {16'd0, mem[254]}, 32'h0301);
        chk("R3 saved pc lo", {16'd0, mem[252]}, 32'h0300);
        chk("R3 saved flags", {16'd0, mem[250]}, 32'h0005);
        chk("R2 nmi order a", {24'd0, alog[base]}, 32'd255);
        chk("R2 nmi order b", {24'd0, alog[base+2]}, 32'd253);
        chk("R2 nmi order c", {24'd0, alog[base+3]}, 32'd252);
        chk("R3 vector hi addr", {24'd0, alog[base+6]}, 32'd3);
        chk("R3 vector lo addr", {24'd0, alog[base+7]}, 32'd2);

        // R9: reset abandons a running sequence
        lat = 5;
        issue(K_NMI);
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 reset sp", {24'd0, sp}, 32'd255);
        chk("R9 reset drops request", {31'd0, mem_req}, 32'd0);
        @(negedge clk);
        @(negedge clk);
        lat = 1;
        rst_n = 1'b1;
        @(negedge clk);
        nmi = 1'b1;
        @(negedge clk);
        nmi = 1'b0;
        wait_redirect("R9 boot");
        chk("R9 boot first", pc, BOOT_PC);
        chk("R9 boot sp", {24'd0, sp}, 32'd255);
        wait_redirect("R9 nmi after boot");
        chk("R9 nmi after boot pc", pc, NMI_PC);
        chk("R9 nmi after boot sp", {24'd0, sp}, 32'd251);

        // R6: return from interrupt restores pc and flags
        issue(K_RTI);
        wait_redirect("R6");
        chk("R6 rti pc", pc, 32'h0000_0300);
        chk("R6 rti flags", {28'd0, flags}, 32'h5);
        chk("R6 rti flags strobe", {31'd0, fload}, 32'd1);
        chk("R6 rti sp", {24'd0, sp}, 32'd255);

        // R8: call wins over simultaneous return
        tgt = 32'h0000_0077;
        cur = 32'h0000_0010;
        wait_ready();
        call = 1'b1;
        ret  = 1'b1;
        @(negedge clk);
        call = 1'b0;
        ret  = 1'b0;
        wait_redirect("R8 priority");
        chk("R8 priority pc", pc, 32'h0000_0077);
        chk("R8 priority sp", {24'd0, sp}, 32'd253);
        chk("R8 priority saved", {16'd0, mem[254]}, 32'h0011);
        @(negedge clk);
        chk("R11 idle without request", {31'd0, mem_req}, 32'd0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule